// File: doc/BRIEF.md
# Lockable Parity-Checked Configuration Register Bank

This block is a small bank of configuration words on a plain 32-bit register bus (word index, write strobe, write data, read data). It exposes two fixed identification words, a control word with a write-disable bit and a sync bit, a watermark word holding two memory-boundary fields, and two enable-mask words. Every write to a writable word carries software-computed odd parity bits in bits 31:29. The bank checks these parity bits and discards a write whose parity does not match.

Writes to the watermark and mask words land in shadow copies. The shadow copies drive the active outputs only while the sync bit is 1. Software clears sync, programs the words, sets sync again (which publishes the shadows), and may then set the write-disable bit. That bit freezes the bank until reset. A write to either identification word does not change the word and produces a one-cycle reset-request pulse.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, word 2 reads 0x20000100, word 3 reads 0xC00FF07F, word 4 reads 0xC0FFFFF8 and word 5 reads 0x6001FFFF. rst_req and par_err are 0 and cfg_locked is 0. The active outputs hold the field values of those words.
- R2: Word 0 reads the ID_WORD parameter. Word 1 reads the total number of enable bits (41 by default) in bits 8:0. Writes never change either word.
- R3: A write to word 0 or word 1 makes rst_req 1 for exactly the cycle after the write edge. rst_req is 0 otherwise. This applies even when the bank is locked.
- R4: Parity is odd. For words 3 to 5, bit 29, bit 30 and bit 31 are the inverted XOR of the defined field bits in byte 0, byte 1 and byte 2. For word 2, bit 29 is the inverse of the write-disable bit (bit 0) and bit 30 is the inverse of the sync bit (bit 8). Reads return the parity computed in this way.
- R5: A write to a writable word whose parity bits do not match its data changes nothing and sets par_err. par_err stays 1 until reset.
- R6: Once the write-disable bit is 1, it stays 1 until reset. Every later write to words 2 to 5 is ignored, and such a write does not touch par_err.
- R7: While sync is 0, a valid write to words 3 to 5 changes the readback but leaves the active outputs unchanged. In the cycle after sync becomes 1, the active outputs equal the stored words.
- R8: While sync is 1, the active outputs follow each stored word one cycle after the write edge.
- R9: A write to word 2 that sets the write-disable bit and also changes the sync bit is rejected as a whole. The write-disable bit and the sync bit both keep their values.
- R10: Reserved bits ignore written values and read as zero. These are word 2 bits 31 and 28:9 and 7:1, word 3 bits 28:20 and 11:7, word 4 bits 28:24, word 5 bits 28:17, and unused word indices 6 and 7.
- R11: Field positions are as follows. ram_wm is word 3 bits 19:12. flash_wm is word 3 bits 6:0. en_mask0 is word 4 bits 23:0. en_mask1 is word 5 bits 16:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 3 | Word index |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data including parity bits |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| rst_req | output | 1 | One-cycle reset request after an identification-word write |
| par_err | output | 1 | Sticky parity-error flag |
| cfg_locked | output | 1 | Write-disable bit |
| cfg_sync | output | 1 | Sync bit |
| ram_wm | output | 8 | Active RAM watermark |
| flash_wm | output | 7 | Active flash watermark |
| en_mask0 | output | 24 | Active first enable mask |
| en_mask1 | output | 17 | Active second enable mask |

## Verification
The assertions assume that bus_addr, bus_we and bus_wdata are stable around each rising edge and that a write lasts exactly one cycle. The conflict and freeze properties read cfg_sync and cfg_locked as they stand in the cycle of the write. The stimulus changes inputs only on falling edges and drops the write strobe after every single-cycle access. Stimulus includes reserved-bit garbage, deliberately wrong parity, a rejected lock-with-sync-change write, and writes both before and after the lock, so that every property has triggering cycles. A behavioural model in the bench tracks the expected state each clock.

// File: rtl/cfgbank_pkg.sv
// Package: word indices, field masks and the odd-parity helper shared by
// the configuration bank and its checker. Assumes a 32-bit word with
// parity in bits 31:29 covering bytes 2..0.
package cfgbank_pkg;
    localparam int WORD_W  = 32;
    localparam int PAR_LSB = 29;
    localparam int NGRP    = 3;

    localparam logic [2:0] IDX_ID0  = 3'd0;
    localparam logic [2:0] IDX_ID1  = 3'd1;
    localparam logic [2:0] IDX_CTRL = 3'd2;
    localparam logic [2:0] IDX_WM   = 3'd3;
    localparam logic [2:0] IDX_MSK0 = 3'd4;
    localparam logic [2:0] IDX_MSK1 = 3'd5;

    localparam int CTRL_WEN_BIT  = 0;
    localparam int CTRL_SYNC_BIT = 8;
    localparam logic [WORD_W-1:0] CTRL_MASK = 32'h0000_0101;

    // Odd parity per byte group: bit g set when byte g holds an even count.
    function automatic logic [NGRP-1:0] odd_par(input logic [WORD_W-1:0] d);
        logic [NGRP-1:0] p;
        for (int g = 0; g < NGRP; g++) begin
            p[g] = ~^d[8*g +: 8];
        end
        return p;
    endfunction
endpackage

// File: rtl/cfgbank_parchk.sv
// Write-side parity checker: derives the expected odd parity of each byte
// group of already-masked write data and compares it with the supplied
// bits. Assumes reserved bits are masked to zero by the caller.
module cfgbank_parchk #(
    parameter int GROUPS = 3
) (
    input  logic [8*GROUPS-1:0] data,
    input  logic [GROUPS-1:0]   par_in,
    input  logic [GROUPS-1:0]   grp_en,
    output logic                par_ok
);
    logic [GROUPS-1:0] par_exp;

    // One inverted reduction per byte group.
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        assign par_exp[g] = ~^data[8*g +: 8];
    end

    // Only the groups enabled for the addressed word take part.
    assign par_ok = ((par_exp ^ par_in) & grp_en) == '0;
endmodule

// File: rtl/cfgbank_cfgreg.sv
// One staged configuration word: a shadow register written from the bus
// and an active register that copies the shadow while sync is high.
// Assumes wr_data is already masked to the word's defined fields.
module cfgbank_cfgreg #(
    parameter int          W         = 32,
    parameter logic [W-1:0] RESET_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         sync,
    output logic [W-1:0] shadow,
    output logic [W-1:0] active
);
    // Shadow capture of accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow <= RESET_VAL;
        else if (wr_en) shadow <= wr_data;
    end

    // Publication of the shadow while sync is high.
    always_ff @(posedge clk) begin
        if (!rst_n)    active <= RESET_VAL;
        else if (sync) active <= shadow;
    end
endmodule

// File: rtl/cfgbank_top.sv
// Configuration register bank: two fixed identification words, a control
// word (write-disable, sync), a watermark word and two enable masks, all
// with software-supplied odd byte parity. Assumes single-cycle writes on a
// simple register bus; read data is combinational on the word index.
module cfgbank_top
    import cfgbank_pkg::*;
#(
    parameter logic [31:0] ID_WORD       = 32'h5C31_0010,
    parameter int          RAMWM_LSB     = 12,
    parameter int          RAMWM_W       = 8,
    parameter int          FLWM_W        = 7,
    parameter int          MASK0_BITS    = 24,
    parameter int          MASK1_BITS    = 17,
    parameter logic [31:0] MASK0_RST_CLR = 32'h0000_0007
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            bus_addr,
    input  logic                  bus_we,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    output logic                  rst_req,
    output logic                  par_err,
    output logic                  cfg_locked,
    output logic                  cfg_sync,
    output logic [RAMWM_W-1:0]    ram_wm,
    output logic [FLWM_W-1:0]     flash_wm,
    output logic [MASK0_BITS-1:0] en_mask0,
    output logic [MASK1_BITS-1:0] en_mask1
);
    localparam logic [31:0] WM_MASK =
        (32'((64'(1) << RAMWM_W) - 1) << RAMWM_LSB) | 32'((64'(1) << FLWM_W) - 1);
    localparam logic [31:0] M0_MASK = 32'((64'(1) << MASK0_BITS) - 1);
    localparam logic [31:0] M1_MASK = 32'((64'(1) << MASK1_BITS) - 1);
    localparam logic [31:0] WM_RST  = WM_MASK;
    localparam logic [31:0] M0_RST  = M0_MASK & ~MASK0_RST_CLR;
    localparam logic [31:0] M1_RST  = M1_MASK;
    localparam logic [31:0] ID1_VAL = 32'(MASK0_BITS + MASK1_BITS);

    logic        wen_q, sync_q, rst_req_q, par_err_q;
    logic [31:0] cur_mask, wdata_m;
    logic [2:0]  grp_en;
    logic        is_id, is_ctrl, is_wm, is_m0, is_m1, is_writable;
    logic        wr_ok, par_ok, ctrl_conflict;
    logic        ctrl_wr, wm_wr, m0_wr, m1_wr, perr_set;
    logic [31:0] wm_shd, wm_act, m0_shd, m0_act, m1_shd, m1_act;
    logic        unused_bits;

    // Address decode of the word index.
    always_comb begin
        is_id   = (bus_addr == IDX_ID0) || (bus_addr == IDX_ID1);
        is_ctrl = (bus_addr == IDX_CTRL);
        is_wm   = (bus_addr == IDX_WM);
        is_m0   = (bus_addr == IDX_MSK0);
        is_m1   = (bus_addr == IDX_MSK1);
        is_writable = is_ctrl | is_wm | is_m0 | is_m1;
    end

    // Field mask and checked parity groups for the addressed word.
    always_comb begin
        cur_mask = '0;
        grp_en   = 3'b111;
        if (is_ctrl) begin
            cur_mask = CTRL_MASK;
            grp_en   = 3'b011;
        end else if (is_wm) begin
            cur_mask = WM_MASK;
        end else if (is_m0) begin
            cur_mask = M0_MASK;
        end else if (is_m1) begin
            cur_mask = M1_MASK;
        end
    end

    assign wdata_m = bus_wdata & cur_mask;

    cfgbank_parchk #(.GROUPS(NGRP)) u_parchk (
        .data   (wdata_m[8*NGRP-1:0]),
        .par_in (bus_wdata[PAR_LSB +: NGRP]),
        .grp_en (grp_en),
        .par_ok (par_ok)
    );

    // Write qualification: lock gate, parity gate, control-word conflict.
    always_comb begin
        wr_ok         = bus_we && is_writable && !wen_q;
        ctrl_conflict = bus_wdata[CTRL_WEN_BIT] && (bus_wdata[CTRL_SYNC_BIT] != sync_q);
        perr_set      = wr_ok && !par_ok;
        ctrl_wr       = wr_ok && par_ok && is_ctrl && !ctrl_conflict;
        wm_wr         = wr_ok && par_ok && is_wm;
        m0_wr         = wr_ok && par_ok && is_m0;
        m1_wr         = wr_ok && par_ok && is_m1;
    end

    // Control word: sticky write-disable and the sync bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wen_q  <= 1'b0;
            sync_q <= 1'b1;
        end else if (ctrl_wr) begin
            wen_q  <= wen_q | bus_wdata[CTRL_WEN_BIT];
            sync_q <= bus_wdata[CTRL_SYNC_BIT];
        end
    end

    // Reset-request pulse and sticky parity-error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_req_q <= 1'b0;
            par_err_q <= 1'b0;
        end else begin
            rst_req_q <= bus_we && is_id;
            par_err_q <= par_err_q | perr_set;
        end
    end

    cfgbank_cfgreg #(.W(32), .RESET_VAL(WM_RST)) u_wm (
        .clk(clk), .rst_n(rst_n), .wr_en(wm_wr), .wr_data(wdata_m),
        .sync(sync_q), .shadow(wm_shd), .active(wm_act)
    );
    cfgbank_cfgreg #(.W(32), .RESET_VAL(M0_RST)) u_m0 (
        .clk(clk), .rst_n(rst_n), .wr_en(m0_wr), .wr_data(wdata_m),
        .sync(sync_q), .shadow(m0_shd), .active(m0_act)
    );
    cfgbank_cfgreg #(.W(32), .RESET_VAL(M1_RST)) u_m1 (
        .clk(clk), .rst_n(rst_n), .wr_en(m1_wr), .wr_data(wdata_m),
        .sync(sync_q), .shadow(m1_shd), .active(m1_act)
    );

    // Read mux: parity regenerated from stored fields, reserved bits zero.
    always_comb begin
        unique case (bus_addr)
            IDX_ID0:  bus_rdata = ID_WORD;
            IDX_ID1:  bus_rdata = ID1_VAL;
            IDX_CTRL: bus_rdata = {1'b0, ~sync_q, ~wen_q, 20'd0, sync_q, 7'd0, wen_q};
            IDX_WM:   bus_rdata = {odd_par(wm_shd), wm_shd[28:0]};
            IDX_MSK0: bus_rdata = {odd_par(m0_shd), m0_shd[28:0]};
            IDX_MSK1: bus_rdata = {odd_par(m1_shd), m1_shd[28:0]};
            default:  bus_rdata = '0;
        endcase
    end

    assign rst_req    = rst_req_q;
    assign par_err    = par_err_q;
    assign cfg_locked = wen_q;
    assign cfg_sync   = sync_q;
    assign ram_wm     = wm_act[RAMWM_LSB +: RAMWM_W];
    assign flash_wm   = wm_act[FLWM_W-1:0];
    assign en_mask0   = m0_act[MASK0_BITS-1:0];
    assign en_mask1   = m1_act[MASK1_BITS-1:0];

    // Bits beyond the published fields are held at zero by the masks.
    assign unused_bits = ^{wdata_m[31:8*NGRP], wm_act, m0_act, m1_act};
endmodule

// File: rtl/cfgbank_chk.sv
// Checker for cfgbank_top: properties over ports and stored shadow words.
// Assumes inputs are stable at each rising edge and writes last one cycle.
module cfgbank_chk #(
    parameter int ACT_W = 56
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       bus_addr,
    input logic             bus_we,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             rst_req,
    input logic             par_err,
    input logic             cfg_locked,
    input logic             cfg_sync,
    input logic [ACT_W-1:0] act_cfg,
    input logic [95:0]      shd_all
);
    // R3: identification-word write produces the request next cycle.
    a_r3_id_write_req: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr <= 3'd1) |=> rst_req);

    // R3: no request without an identification-word write.
    a_r3_no_spurious_req: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr <= 3'd1) |=> !rst_req);

    // R5: the parity-error flag is sticky.
    a_r5_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err);

    // R6: the write-disable bit is sticky.
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> cfg_locked);

    // R6: a locked bank keeps its stored words, sync bit and error flag.
    a_r6_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_locked |=> ($stable(shd_all) && $stable(cfg_sync) && $stable(par_err)));

    // R7: active outputs hold while sync is low.
    a_r7_hold_unsynced: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sync |=> $stable(act_cfg));

    // R9: locking together with a sync change is rejected.
    a_r9_conflict_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 3'd2 && !cfg_locked && bus_wdata[0] &&
         (bus_wdata[8] != cfg_sync)) |=> (!cfg_locked && $stable(cfg_sync)));

    // R4: readback of staged words carries consistent odd parity.
    a_r4_readback_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr >= 3'd3 && bus_addr <= 3'd5) |->
        (bus_rdata[31:29] == ~{^bus_rdata[23:16], ^bus_rdata[15:8], ^bus_rdata[7:0]}));

    // R10: reserved bits of the control word read as zero.
    a_r10_ctrl_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd2) |->
        (bus_rdata[31] == 1'b0 && bus_rdata[28:9] == '0 && bus_rdata[7:1] == '0));
endmodule

bind cfgbank_top cfgbank_chk #(
    .ACT_W(RAMWM_W + FLWM_W + MASK0_BITS + MASK1_BITS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .rst_req    (rst_req),
    .par_err    (par_err),
    .cfg_locked (cfg_locked),
    .cfg_sync   (cfg_sync),
    .act_cfg    ({en_mask1, en_mask0, flash_wm, ram_wm}),
    .shd_all    ({wm_shd, m0_shd, m1_shd})
);

// File: tb/cfgbank_top_tb.sv
// Bench for cfgbank_top: behavioural reference model updated each clock,
// outputs compared on every falling edge, readback compared on demand.
module cfgbank_top_tb;
    localparam logic [31:0] ID0 = 32'h5C31_0010;
    localparam logic [31:0] WMM = 32'h000F_F07F;
    localparam logic [31:0] M0M = 32'h00FF_FFFF;
    localparam logic [31:0] M1M = 32'h0001_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req, par_err, cfg_locked, cfg_sync;
    logic [7:0]  ram_wm;
    logic [6:0]  flash_wm;
    logic [23:0] en_mask0;
    logic [16:0] en_mask1;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    // Reference model state.
    logic        m_wen, m_sync, m_perr, m_rst;
    logic [31:0] m_wm, m_m0, m_m1, a_wm, a_m0, a_m1;

    cfgbank_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req),
        .par_err(par_err), .cfg_locked(cfg_locked), .cfg_sync(cfg_sync),
        .ram_wm(ram_wm), .flash_wm(flash_wm), .en_mask0(en_mask0), .en_mask1(en_mask1)
    );

    always #10 clk = ~clk;

    function automatic logic [2:0] par3(input logic [31:0] d);
        return {~^d[23:16], ~^d[15:8], ~^d[7:0]};
    endfunction

    // Word with correct parity for the given field mask, reserved bits as given.
    function automatic logic [31:0] mkw(input logic [31:0] d, input logic [31:0] msk);
        return {par3(d & msk), d[28:0]};
    endfunction

    function automatic logic [31:0] ctrl_word(input logic wen, input logic sync);
        return {1'b0, ~sync, ~wen, 20'd0, sync, 7'd0, wen};
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return ID0;
            3'd1: return 32'd41;
            3'd2: return ctrl_word(m_wen, m_sync);
            3'd3: return {par3(m_wm), m_wm[28:0]};
            3'd4: return {par3(m_m0), m_m0[28:0]};
            3'd5: return {par3(m_m1), m_m1[28:0]};
            default: return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_wen = 0; m_sync = 1; m_perr = 0; m_rst = 0;
        m_wm = 32'h000F_F07F; m_m0 = 32'h00FF_FFF8; m_m1 = 32'h0001_FFFF;
        a_wm = m_wm; a_m0 = m_m0; a_m1 = m_m1;
    endtask

    task automatic model_step(input logic we, input logic [2:0] a, input logic [31:0] wd);
        if (m_sync) begin
            a_wm = m_wm; a_m0 = m_m0; a_m1 = m_m1;
        end
        m_rst = we && (a <= 3'd1);
        if (we && a >= 3'd2 && a <= 3'd5 && !m_wen) begin
            case (a)
                3'd2: begin
                    if (wd[30:29] != {~wd[8], ~wd[0]}) m_perr = 1;
                    else if (!(wd[0] && wd[8] != m_sync)) begin
                        m_wen = wd[0]; m_sync = wd[8];
                    end
                end
                3'd3: if (wd[31:29] != par3(wd & WMM)) m_perr = 1; else m_wm = wd & WMM;
                3'd4: if (wd[31:29] != par3(wd & M0M)) m_perr = 1; else m_m0 = wd & M0M;
                default: if (wd[31:29] != par3(wd & M1M)) m_perr = 1; else m_m1 = wd & M1M;
            endcase
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-clock comparison of all outputs against the model.
    task automatic compare_all();
        chk("R3 rst_req", 32'(rst_req), 32'(m_rst));
        chk("R5 par_err", 32'(par_err), 32'(m_perr));
        chk("R6 cfg_locked", 32'(cfg_locked), 32'(m_wen));
        chk("R9 cfg_sync", 32'(cfg_sync), 32'(m_sync));
        chk("R7 R8 R11 ram_wm", 32'(ram_wm), 32'(a_wm[19:12]));
        chk("R7 R8 R11 flash_wm", 32'(flash_wm), 32'(a_wm[6:0]));
        chk("R7 R8 R11 en_mask0", 32'(en_mask0), 32'(a_m0[23:0]));
        chk("R7 R8 R11 en_mask1", 32'(en_mask1), 32'(a_m1[16:0]));
    endtask

    task automatic step(input logic we, input logic [2:0] a, input logic [31:0] wd);
        bus_we = we; bus_addr = a; bus_wdata = wd;
        @(posedge clk);
        model_step(we, a, wd);
        @(negedge clk);
        bus_we = 0;
        compare_all();
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, model_read(a));
    endtask

    task automatic rd_all(input string tag);
        for (int i = 0; i < 8; i++) rd(3'(i), tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; total++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        compare_all();
        // R1 R2 R10: reset readback of every index
        chk("R1 ctrl reset", bus_rdata & 0, 0);
        rd(3'd2, "R1 ctrl reset");
        rd(3'd3, "R1 wm reset");
        rd(3'd4, "R1 mask0 reset");
        rd(3'd5, "R1 mask1 reset");
        rd(3'd0, "R2 id0");
        rd(3'd1, "R2 id1");
        rd(3'd6, "R10 unused index");
        // R3: identification writes give a single-cycle request, word unchanged
        step(1, 3'd0, 32'hFFFF_FFFF);
        step(0, 3'd0, 32'h0);
        rd(3'd0, "R2 id0 after write");
        step(1, 3'd1, 32'h1234_5678);
        rd(3'd1, "R2 id1 after write");
        step(0, 3'd0, 32'h0);
        // R7: clear sync, then stage values; active outputs must hold
        step(1, 3'd2, ctrl_word(0, 0));
        step(1, 3'd3, mkw(32'h1FF3_C815, WMM));
        rd(3'd3, "R4 R10 wm staged readback");
        step(0, 3'd0, 32'h0);
        // R5: bad parity discarded and flagged
        step(1, 3'd4, mkw(32'h0012_3456, M0M) ^ 32'h2000_0000);
        rd(3'd4, "R5 mask0 after bad parity");
        step(1, 3'd4, mkw(32'h1FA5_5A0F, M0M));
        rd(3'd4, "R10 mask0 reserved");
        step(1, 3'd2, ctrl_word(0, 0) ^ 32'h4000_0000);
        rd(3'd2, "R5 ctrl after bad parity");
        // R7: raising sync publishes the shadows one cycle later
        step(1, 3'd2, ctrl_word(0, 1) | 32'h8FFF_FEFE);
        rd(3'd2, "R10 ctrl reserved");
        step(0, 3'd0, 32'h0);
        // R8: while sync is high, outputs follow after one cycle
        step(1, 3'd5, mkw(32'h0000_A5C3, M1M));
        step(0, 3'd0, 32'h0);
        step(1, 3'd5, mkw(32'hFFFE_0001, M1M));
        rd(3'd5, "R10 mask1 reserved");
        step(0, 3'd0, 32'h0);
        // R9: lock with a sync change is rejected
        step(1, 3'd2, ctrl_word(1, 0));
        rd(3'd2, "R9 ctrl after conflict");
        // R6: lock, then every write is ignored
        step(1, 3'd2, ctrl_word(1, 1));
        rd(3'd2, "R6 ctrl locked");
        step(1, 3'd3, mkw(32'h0000_1001, WMM));
        step(1, 3'd2, ctrl_word(0, 0));
        step(1, 3'd4, 32'h0000_0000);
        step(1, 3'd5, mkw(32'h0000_0003, M1M));
        rd_all("R6 frozen readback");
        // R3: identification write still requests reset while locked
        step(1, 3'd1, 32'h0);
        step(0, 3'd0, 32'h0);
        // Reset again returns the bank to its initial state (R1)
        rst_n = 0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
        compare_all();
        rd_all("R1 after second reset");
        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule